// File: doc/BRIEF.md
# Serial Flash Page-Program Sequencer

This block takes one host request (a start address, a byte count and a stream of data bytes) and turns it into the command traffic that a serial NOR flash needs to store those bytes. The run is cut into chunks so that no chunk crosses a page boundary. The page size is 2^`page_shift` bytes and is set at run time. For each chunk the block sends a write-enable command. It then reads the status register until the device is idle, and goes on only if the write-enable latch is set. Next it sends the program command with the address and the chunk's bytes in one frame. Finally it reads status again until the write-in-progress flag clears.

The flash side is a byte-wide command port to a frame engine. The engine holds chip select asserted from the first byte of a frame up to and including the byte marked `fl_last`. A byte marked `fl_capture` asks the engine to return the byte shifted in during that transfer on `fl_rdata`, with a one-cycle `fl_rvalid` pulse. Both `fl_valid`/`fl_ready` and `wr_valid`/`wr_ready` are valid/ready streams. A byte moves only on a cycle where valid and ready are both high. Once valid is raised, that side keeps valid, the byte and its flags unchanged until ready is seen. The data stream is consumed only while program-data bytes are going out, and `wr_ready` follows `fl_ready` there. Status polls are spaced by a programmable number of clock cycles. Each wait for the device is limited to `MAX_POLLS` status reads. A run ends with a one-cycle `done` pulse and an error code.

Top module: `flash_prog_seq`

## Requirements
- R1: A request with `req_len` = 0 sends no flash byte. It raises `done` in the cycle after it is accepted, with `err` = 0.
- R2: Each program frame covers the lesser of the remaining byte count and (2^`page_shift` minus the start address modulo 2^`page_shift`). Consecutive frames continue at the following address. With `page_shift` = 8 the page is 256 bytes.
- R3: Every chunk starts with a one-byte frame 0x06 (write enable). A status read follows it: a frame of opcode 0x05 and then one `fl_capture` byte that also carries `fl_last`.
- R4: After the write enable, status bit 0 (busy) must read clear before bit 1 (write-enable latch) is judged. If the latch then reads clear, the run ends with `err` = 1 and no program frame is sent.
- R5: A program frame is opcode 0x02, then the address bytes with the most significant byte first, then the chunk's data bytes. `fl_last` is set only on the final data byte.
- R6: After each program frame the block reads status until bit 0 reads clear. Only then does it start the next chunk or end the run with `err` = 0.
- R7: A single wait makes at most `MAX_POLLS` status reads. If bit 0 is still set on the last allowed read, the run ends: with `err` = 2 after a program frame, or with `err` = 1 after a write enable. If bit 0 clears on that last read, the run carries on normally.
- R8: Two successive status-read frames start at least `poll_gap` clock cycles apart.
- R9: `req_ready` is high only while idle. It is low from acceptance until the cycle after the one-cycle `done` pulse, and `done` never lasts longer than one cycle.
- R10: `fl_valid` together with `fl_byte` and `fl_last` stays unchanged while `fl_ready` is low. Program data is taken from the `wr_*` stream only when a flash byte moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_shift | input | SH_W | Page size as a power of two |
| poll_gap | input | GAP_W | Minimum cycles between status polls |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | 8*ADDR_BYTES | Start address |
| req_len | input | LEN_W | Number of bytes to program |
| wr_valid | input | 1 | Data byte present |
| wr_ready | output | 1 | Data byte consumed |
| wr_data | input | 8 | Data byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 write-enable failure, 2 device stayed busy |
| fl_valid | output | 1 | Command byte present |
| fl_ready | input | 1 | Frame engine takes the byte |
| fl_byte | output | 8 | Command, address or data byte |
| fl_last | output | 1 | Final byte of the frame |
| fl_capture | output | 1 | Return the byte read during this transfer |
| fl_rvalid | input | 1 | Captured byte available |
| fl_rdata | input | 8 | Captured byte (status register) |

## Verification
The sharpest collision is on one status read, where the device reports idle and the retry budget runs out at the same moment. The bench provokes it by making the flash model report busy for exactly `MAX_POLLS`−1 reads, which must lead to success. It then makes the model report busy for `MAX_POLLS` reads, which must end in `err` = 2 with no further frames. It also counts the status reads in each case. A similar overlap occurs after write enable, where the busy flag and a clear latch are reported together. There the bench checks how many reads come before the latch failure.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WEN, ST_GAP, ST_SR_OP, ST_SR_DUM, ST_SR_WAIT,
    ST_PP_OP, ST_PP_ADDR, ST_PP_DATA, ST_DONE
  } seq_state_e;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_WEL  = 2'd1;
  localparam logic [1:0] ERR_RDY  = 2'd2;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_PROG = 8'h02;

  localparam logic [7:0] SR_BUSY_MASK  = 8'h01;
  localparam logic [7:0] SR_LATCH_MASK = 8'h02;

endpackage

// File: rtl/flash_chunk_calc.sv
module flash_chunk_calc #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int SH_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  rem,
  input  logic [SH_W-1:0]   page_shift,
  output logic [LEN_W-1:0]  chunk
);
  localparam int CW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  logic [CW-1:0] page, offs, room;

  always_comb begin
    page  = CW'(1) << page_shift;
    offs  = CW'(addr) & (page - CW'(1));
    room  = page - offs;
    chunk = (CW'(rem) < room) ? rem : room[LEN_W-1:0];
  end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int GAP_W     = 16,
  parameter int MAX_POLLS = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             again,
  input  logic [GAP_W-1:0] gap_val,
  output logic             gap_zero,
  output logic             last_try
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      cnt_q <= '0;
    end else begin
      if (start || again)   gap_q <= gap_val;
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
      if (start)            cnt_q <= '0;
      else if (again)       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gap_zero = (gap_q == '0);
  assign last_try = (cnt_q == CNT_W'(MAX_POLLS - 1));

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_POLLS)); // R7
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 16,
  parameter int SH_W       = 4,
  parameter int GAP_W      = 16,
  parameter int MAX_POLLS  = 10000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SH_W-1:0]         page_shift,
  input  logic [GAP_W-1:0]        poll_gap,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [7:0]              wr_data,
  output logic                    done,
  output logic [1:0]              err,
  output logic                    fl_valid,
  input  logic                    fl_ready,
  output logic [7:0]              fl_byte,
  output logic                    fl_last,
  output logic                    fl_capture,
  input  logic                    fl_rvalid,
  input  logic [7:0]              fl_rdata
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  seq_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, chunk_q, left_q, chunk;
  logic [IDX_W-1:0]  aidx;
  logic              after_pp;
  logic [1:0]        err_q;
  logic              fire, sr_busy, sr_latch, poll_start, poll_again;
  logic              gap_zero, last_try;
  logic [7:0]        addr_bytes [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    assign addr_bytes[g] = addr_q[8*(ADDR_BYTES-1-g) +: 8];
  end

  flash_chunk_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SH_W(SH_W)) u_chunk (
    .addr(addr_q), .rem(rem_q), .page_shift(page_shift), .chunk(chunk)
  );

  flash_poll_ctrl #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .start(poll_start), .again(poll_again),
    .gap_val(poll_gap), .gap_zero(gap_zero), .last_try(last_try)
  );

  assign fire       = fl_valid && fl_ready;
  assign sr_busy    = |(fl_rdata & SR_BUSY_MASK);
  assign sr_latch   = |(fl_rdata & SR_LATCH_MASK);
  assign poll_start = fire && ((st == ST_WEN) || (st == ST_PP_DATA && left_q == LEN_W'(1)));
  assign poll_again = (st == ST_SR_WAIT) && fl_rvalid && sr_busy && !last_try;
  assign req_ready  = (st == ST_IDLE);
  assign done       = (st == ST_DONE);
  assign err        = err_q;

  always_comb begin
    fl_valid   = 1'b0;
    fl_byte    = 8'h00;
    fl_last    = 1'b0;
    fl_capture = 1'b0;
    wr_ready   = 1'b0;
    case (st)
      ST_WEN:     begin fl_valid = 1'b1; fl_byte = OP_WREN; fl_last = 1'b1; end
      ST_SR_OP:   begin fl_valid = 1'b1; fl_byte = OP_RDSR; end
      ST_SR_DUM:  begin fl_valid = 1'b1; fl_last = 1'b1; fl_capture = 1'b1; end
      ST_PP_OP:   begin fl_valid = 1'b1; fl_byte = OP_PROG; end
      ST_PP_ADDR: begin fl_valid = 1'b1; fl_byte = addr_bytes[aidx]; end
      ST_PP_DATA: begin
        fl_valid = wr_valid;
        fl_byte  = wr_data;
        fl_last  = (left_q == LEN_W'(1));
        wr_ready = fl_ready;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      chunk_q  <= '0;
      left_q   <= '0;
      aidx     <= '0;
      after_pp <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rem_q  <= req_len;
          err_q  <= ERR_NONE;
          st     <= (req_len == '0) ? ST_DONE : ST_WEN;
        end
        ST_WEN: if (fire) begin
          after_pp <= 1'b0;
          st       <= ST_GAP;
        end
        ST_GAP:    if (gap_zero) st <= ST_SR_OP;
        ST_SR_OP:  if (fire) st <= ST_SR_DUM;
        ST_SR_DUM: if (fire) st <= ST_SR_WAIT;
        ST_SR_WAIT: if (fl_rvalid) begin
          if (sr_busy) begin
            if (last_try) begin
              err_q <= after_pp ? ERR_RDY : ERR_WEL;
              st    <= ST_DONE;
            end else begin
              st <= ST_GAP;
            end
          end else if (!after_pp) begin
            if (sr_latch) st <= ST_PP_OP;
            else begin
              err_q <= ERR_WEL;
              st    <= ST_DONE;
            end
          end else begin
            addr_q <= addr_q + ADDR_W'(chunk_q);
            rem_q  <= rem_q - chunk_q;
            st     <= (rem_q == chunk_q) ? ST_DONE : ST_WEN;
          end
        end
        ST_PP_OP: if (fire) begin
          chunk_q <= chunk;
          left_q  <= chunk;
          aidx    <= '0;
          st      <= ST_PP_ADDR;
        end
        ST_PP_ADDR: if (fire) begin
          if (aidx == IDX_W'(ADDR_BYTES - 1)) st <= ST_PP_DATA;
          else aidx <= aidx + 1'b1;
        end
        ST_PP_DATA: if (fire) begin
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            after_pp <= 1'b1;
            st       <= ST_GAP;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R9
  AST_HOLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_byte) && $stable(fl_last))); // R10
  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PP_OP && fire) |-> (chunk != '0 && chunk <= rem_q)); // R2
  AST_PROG_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_PP_OP) |-> $past(fl_rvalid && sr_latch && !sr_busy)); // R4
endmodule

// File: tb/flash_prog_seq_tb.sv
module flash_prog_seq_tb;
  localparam int MAXP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  page_shift = 4'd8;
  logic [15:0] poll_gap = 16'd0;
  logic req_valid = 1'b0, req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data;
  logic done;
  logic [1:0] err;
  logic fl_valid, fl_ready = 1'b1, fl_last, fl_capture;
  logic [7:0] fl_byte;
  logic fl_rvalid = 1'b0;
  logic [7:0] fl_rdata = '0;

  always #2 clk = ~clk;

  flash_prog_seq #(.ADDR_BYTES(3), .LEN_W(16), .SH_W(4), .GAP_W(16), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .page_shift(page_shift), .poll_gap(poll_gap),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .done(done), .err(err),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_byte(fl_byte), .fl_last(fl_last),
    .fl_capture(fl_capture), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata)
  );

  int checks = 0, fails = 0;
  int cyc = 0, nfr = 0, nrd = 0, n_pp = 0, fidx = 0, cur_op = 0, pa = 0, plen = 0;
  int busy_cnt = 0, busy_wen = 0, busy_pp = 0, src_idx = 0;
  bit wel = 1'b0, wel_fail = 1'b0, stall = 1'b0;
  int op_log [256];
  int rd_cyc [256];
  int pp_addr [16];
  int pp_len [16];
  logic [7:0] mem [4096];

  assign wr_data = 8'((src_idx * 7) + 3);

  // Flash and data-source model
  always @(posedge clk) begin
    cyc++;
    fl_rvalid <= 1'b0;
    fl_ready  <= stall ? ~fl_ready : 1'b1;
    if (!wr_valid || wr_ready) wr_valid <= stall ? ~wr_valid : 1'b1;
    if (wr_valid && wr_ready) src_idx <= src_idx + 1;
    if (fl_valid && fl_ready) begin
      if (fidx == 0) begin
        cur_op = int'(fl_byte);
        if (nfr < 256) op_log[nfr] = cur_op;
        nfr++;
        if (cur_op == 5 && nrd < 256) begin rd_cyc[nrd] = cyc; nrd++; end
        if (cur_op == 2) begin pa = 0; plen = 0; end
      end else if (cur_op == 2) begin
        if (fidx <= 3) pa = (pa << 8) | int'(fl_byte);
        else begin mem[(pa + plen) % 4096] = fl_byte; plen++; end
      end
      if (fl_capture) begin
        fl_rvalid <= 1'b1;
        fl_rdata  <= {6'd0, wel, (busy_cnt > 0)};
        if (busy_cnt > 0) busy_cnt--;
      end
      if (fl_last) begin
        fidx = 0;
        if (cur_op == 6) begin wel = !wel_fail; busy_cnt = busy_wen; end
        if (cur_op == 2) begin
          wel = 1'b0; busy_cnt = busy_pp;
          if (n_pp < 16) begin pp_addr[n_pp] = pa; pp_len[n_pp] = plen; end
          n_pp++;
        end
      end else fidx++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log(input int bw, input int bp, input bit wf, input bit st);
    @(negedge clk);
    nfr = 0; nrd = 0; n_pp = 0; busy_cnt = 0;
    busy_wen = bw; busy_pp = bp; wel_fail = wf; stall = st;
  endtask

  // Issue a request and wait for done; checks R9 along the way
  task automatic run(input int addr, input int len, output int e, output int waited);
    int bad_ready = 0;
    @(negedge clk);
    req_addr = 24'(addr); req_len = 16'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 30000) begin
      if (req_ready) bad_ready++;
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R9 done seen", int'(done), 1);
    chk(bad_ready == 0, "R9 ready low while busy", bad_ready, 0);
    e = int'(err);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R9 done one cycle then ready", int'({done, req_ready}), 1);
  endtask

  task automatic chk_mem(input int addr, input int len, input int base, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (mem[(addr + i) % 4096] !== 8'(((base + i) * 7) + 3)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
    chk(done == 1'b0, "R9 reset done", int'(done), 0);
    chk(fl_valid == 1'b0, "R9 reset no flash traffic", int'(fl_valid), 0);
  endtask

  task automatic t_zero_len();  // R1
    int e, w;
    clear_log(0, 0, 0, 0);
    run(24'h000123, 0, e, w);
    chk(w == 0, "R1 done right after accept", w, 0);
    chk(nfr == 0, "R1 no frames", nfr, 0);
    chk(e == 0, "R1 err", e, 0);
  endtask

  task automatic t_split16();  // R2 R3 R5 R6
    int e, w, base, bad;
    int exp_a [4] = '{'h0A, 'h10, 'h20, 'h30};
    int exp_l [4] = '{6, 16, 16, 2};
    int pat [6] = '{6, 5, 2, 5, 5, 5};
    page_shift = 4'd4;
    clear_log(0, 2, 0, 0);
    base = src_idx;
    run('h00000A, 40, e, w);
    chk(e == 0, "R6 err ok", e, 0);
    chk(n_pp == 4, "R2 program frames", n_pp, 4);
    for (int i = 0; i < 4; i++) begin
      chk(pp_addr[i] == exp_a[i], "R5 frame address", pp_addr[i], exp_a[i]);
      chk(pp_len[i] == exp_l[i], "R2 chunk length", pp_len[i], exp_l[i]);
    end
    chk(nfr == 24, "R3 frame count", nfr, 24);
    bad = 0;
    for (int i = 0; i < 24; i++) if (op_log[i] != pat[i % 6]) bad++;
    chk(bad == 0, "R3 R6 opcode order", bad, 0);
    chk_mem('h0A, 40, base, "R5 data bytes");
  endtask

  task automatic t_page256_stall();  // R2 R10
    int e, w, base;
    page_shift = 4'd8;
    clear_log(0, 1, 0, 1);
    base = src_idx;
    run('h0100F0, 32, e, w);
    chk(e == 0, "R10 err ok under stall", e, 0);
    chk(n_pp == 2, "R2 256-byte page split", n_pp, 2);
    chk(pp_addr[0] == 'h0100F0 && pp_len[0] == 16, "R2 first chunk", pp_len[0], 16);
    chk(pp_addr[1] == 'h010100 && pp_len[1] == 16, "R2 second chunk", pp_addr[1], 'h010100);
    chk_mem('h0100F0, 32, base, "R10 data under back-pressure");
  endtask

  task automatic t_wen_busy();  // R4
    int e, w, bad;
    clear_log(3, 0, 0, 0);
    run('h000200, 4, e, w);
    chk(e == 0, "R4 err ok", e, 0);
    bad = 0;
    if (op_log[0] != 6) bad++;
    for (int i = 1; i < 5; i++) if (op_log[i] != 5) bad++;
    if (op_log[5] != 2) bad++;
    chk(bad == 0, "R4 waits for idle before program", bad, 0);
    clear_log(2, 0, 1, 0);
    run('h000300, 4, e, w);
    chk(e == 1, "R4 latch clear error", e, 1);
    chk(n_pp == 0, "R4 no program frame", n_pp, 0);
    chk(nrd == 3, "R4 latch judged after busy clears", nrd, 3);
  endtask

  task automatic t_poll_limit();  // R7
    int e, w;
    clear_log(0, MAXP - 1, 0, 0);
    run('h000400, 3, e, w);
    chk(e == 0, "R7 clears on last allowed read", e, 0);
    chk(nrd == 1 + MAXP, "R7 reads when clearing at limit", nrd, 1 + MAXP);
    clear_log(0, MAXP, 0, 0);
    run('h000500, 3, e, w);
    chk(e == 2, "R7 ready failure", e, 2);
    chk(nrd == 1 + MAXP, "R7 reads stop at limit", nrd, 1 + MAXP);
    chk(n_pp == 1, "R7 no further chunk", n_pp, 1);
    clear_log(MAXP, 0, 0, 0);
    run('h000600, 3, e, w);
    chk(e == 1, "R7 busy after enable is enable failure", e, 1);
    chk(nrd == MAXP && n_pp == 0, "R7 enable-phase read count", nrd, MAXP);
  endtask

  task automatic t_gap();  // R8
    int e, w, mind;
    poll_gap = 16'd20;
    clear_log(0, 3, 0, 0);
    run('h000700, 2, e, w);
    chk(e == 0, "R8 err ok", e, 0);
    mind = 1 << 30;
    for (int i = 1; i < nrd; i++) if (rd_cyc[i] - rd_cyc[i-1] < mind) mind = rd_cyc[i] - rd_cyc[i-1];
    chk(nrd == 5 && mind >= 20, "R8 poll spacing", mind, 20);
    poll_gap = 16'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_zero_len();
    t_split16();
    t_page256_stall();
    t_wen_busy();
    t_poll_limit();
    t_gap();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule